// File: doc/BRIEF.md
# Zero-Crossing Volume Update Controller

This block sits in front of a six-channel output gain stage and decides the moment at which a newly requested attenuation or mute setting starts to apply to each channel. A setting is written into a per-channel pending slot with a load strobe. It then waits until that channel's sample stream crosses zero, so the level step does not cause an audible click. If no crossing arrives, the setting is forced in after a frame-count timeout. A per-channel acceptance flag is high while a setting is waiting. A global control bit turns the deferral off, so that loads apply at once.

The block also mutes every channel when all six channels carry silence (sample value 0 or the all-ones code -1) for a long run of frames. It mutes every channel at once, with no delay, while an external clock-error input is high. The gain arithmetic itself is not part of the block: it only delivers the attenuation codes and mute bits that are currently in force.

Top module: `zc_vol_ctrl`

## Requirements
- R1: After reset, every applied attenuation code is 0, every mute output is 0 and every acceptance flag is 0.
- R2: Attenuation codes are in 1 dB steps from 0 to 86. A requested code above 86 is applied as 86.
- R3: When zc_off is 1, a load on channel i updates att_o and channel mute i at the next clock edge, and acc[i] stays 0.
- R4: When zc_off is 0, a load on channel i sets acc[i] to 1 and leaves the applied values unchanged. On a frame strobe where channel i's sample is zero, or where its sign bit differs from the sign bit of that channel's previous frame, the pending values are applied and acc[i] returns to 0. Other channels are unaffected. The previous sign bit starts at 0 after reset.
- R5: A second load on channel i while acc[i] is 1 replaces the pending values, and acc[i] stays 1.
- R6: The mute request follows the same deferral as attenuation. mute_o[i] is the applied channel mute, ORed with the automatic mute and with clk_err.
- R7: A pending change that sees no zero crossing is applied on the second wrap of a free-running 9-bit frame counter after the load. This is between 512 and 1024 frames after the load.
- R8: With auto_en at 1, once 512 consecutive frames have all six samples equal to 0 or -1, all of mute_o go to 1. The first frame in which any channel carries another value releases them.
- R9: With auto_en at 0, silent frames never raise mute_o.
- R10: While clk_err is 1, all of mute_o are 1 in the same cycle.
- R11: Raising zc_off while a change is pending applies that change at the next clock edge and clears acc.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle strobe, once per frame |
| smp_i | input | NCH*SW | Signed samples, channel i in bits [i*SW +: SW] |
| att_req | input | NCH*AW | Requested attenuation codes, channel i in [i*AW +: AW] |
| mute_req | input | NCH | Requested mute bits |
| req_ld | input | NCH | Per-channel load strobes for att_req/mute_req |
| zc_off | input | 1 | 1: settings apply immediately |
| auto_en | input | 1 | Enables the silence auto-mute |
| clk_err | input | 1 | Clock error, forces all mutes |
| att_o | output | NCH*AW | Applied attenuation codes |
| mute_o | output | NCH | Effective mute per channel |
| acc | output | NCH | Acceptance flag, high while a setting is pending |

## Verification
A wrong pending flag or a wrong previous-sign register shows up on att_o and acc at the first frame strobe whose sample should, or should not, count as a crossing. The bench places such frames directly after each load, so the error is visible within one or two frames. A frame counter or wrap latch that is off shows as a timeout outside the 512 to 1024 frame window; the bench measures this on acc. A silence-run counter that is off by even one frame is caught at the 511th and 512th silent frames, on mute_o.

// File: rtl/zc_vol_ctrl.sv
module zc_vol_ctrl #(
  parameter int NCH     = 6,
  parameter int SW      = 20,
  parameter int AW      = 7,
  parameter int ATT_MAX = 86,
  parameter int TW      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [NCH*SW-1:0] smp_i,
  input  logic [NCH*AW-1:0] att_req,
  input  logic [NCH-1:0]    mute_req,
  input  logic [NCH-1:0]    req_ld,
  input  logic              zc_off,
  input  logic              auto_en,
  input  logic              clk_err,
  output logic [NCH*AW-1:0] att_o,
  output logic [NCH-1:0]    mute_o,
  output logic [NCH-1:0]    acc
);
  localparam int RW = TW + 1;
  localparam logic [RW-1:0] RUN_LIM = RW'(1) << TW;
  localparam logic [AW-1:0] AMAX = AW'(ATT_MAX);

  logic [AW-1:0] att_q [NCH];
  logic [AW-1:0] pend_a [NCH];
  logic [NCH-1:0] mute_q, pend_m, wrap1, sgn_q, zc, silent;
  logic [TW-1:0] fcnt;
  logic [RW-1:0] run;
  logic fwrap, auto_m;

  function automatic logic [AW-1:0] clamp(input logic [AW-1:0] v);
    return (v > AMAX) ? AMAX : v;
  endfunction

  assign fwrap  = &fcnt;
  assign auto_m = auto_en && (run == RUN_LIM);
  assign mute_o = mute_q | {NCH{auto_m | clk_err}};

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      zc[i]     = (smp_i[i*SW +: SW] == '0) || (smp_i[i*SW+SW-1] != sgn_q[i]);
      silent[i] = (smp_i[i*SW +: SW] == '0) || (&smp_i[i*SW +: SW]);
      att_o[i*AW +: AW] = att_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fcnt   <= '0;
      run    <= '0;
      sgn_q  <= '0;
      mute_q <= '0;
      pend_m <= '0;
      wrap1  <= '0;
      acc    <= '0;
      for (int i = 0; i < NCH; i++) begin
        att_q[i]  <= '0;
        pend_a[i] <= '0;
      end
    end else begin
      if (frame_stb) begin
        fcnt <= fcnt + 1'b1;
        for (int i = 0; i < NCH; i++) sgn_q[i] <= smp_i[i*SW+SW-1];
        if (&silent) begin
          if (run != RUN_LIM) run <= run + 1'b1;
        end else begin
          run <= '0;
        end
      end
      for (int i = 0; i < NCH; i++) begin
        if (req_ld[i]) begin
          pend_a[i] <= clamp(att_req[i*AW +: AW]);
          pend_m[i] <= mute_req[i];
          wrap1[i]  <= 1'b0;
          if (zc_off) begin
            att_q[i]  <= clamp(att_req[i*AW +: AW]);
            mute_q[i] <= mute_req[i];
            acc[i]    <= 1'b0;
          end else begin
            acc[i] <= 1'b1;
          end
        end else if (acc[i]) begin
          if (zc_off || (frame_stb && (zc[i] || (wrap1[i] && fwrap)))) begin
            att_q[i]  <= pend_a[i];
            mute_q[i] <= pend_m[i];
            acc[i]    <= 1'b0;
          end else if (frame_stb && fwrap) begin
            wrap1[i] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/zc_vol_ctrl_chk.sv
module zc_vol_ctrl_chk #(
  parameter int NCH     = 6,
  parameter int AW      = 7,
  parameter int ATT_MAX = 86,
  parameter int TW      = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_stb,
  input logic              zc_off,
  input logic              clk_err,
  input logic [NCH-1:0]    req_ld,
  input logic [NCH*AW-1:0] att_o,
  input logic [NCH-1:0]    mute_o,
  input logic [NCH-1:0]    acc
);
  localparam int CW = TW + 2;
  localparam logic [CW-1:0] WLIM = CW'(1) << (TW + 1);

  a_r10_err_mute: assert property (@(posedge clk) disable iff (!rst_n)
    clk_err |-> (&mute_o));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!zc_off && req_ld == '0 && !frame_stb) |=> $stable(att_o));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] wcnt;
    always_ff @(posedge clk) begin
      if (!rst_n || req_ld[i] || !acc[i]) wcnt <= '0;
      else if (frame_stb) wcnt <= wcnt + 1'b1;
    end

    a_r2_att_max: assert property (@(posedge clk) disable iff (!rst_n)
      att_o[i*AW +: AW] <= AW'(ATT_MAX));

    a_r3_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
      (zc_off && req_ld[i]) |=> !acc[i]);

    a_r4_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!zc_off && req_ld[i]) |=> acc[i]);

    a_r7_timeout: assert property (@(posedge clk) disable iff (!rst_n)
      acc[i] |-> (wcnt < WLIM));
  end
endmodule

bind zc_vol_ctrl zc_vol_ctrl_chk #(.NCH(NCH), .AW(AW), .ATT_MAX(ATT_MAX), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .zc_off(zc_off), .clk_err(clk_err),
  .req_ld(req_ld), .att_o(att_o), .mute_o(mute_o), .acc(acc));

// File: tb/sim_zc_vol_ctrl.sv
module sim_zc_vol_ctrl;
  localparam int NCH = 6, SW = 20, AW = 7;
  logic clk = 0, rst_n = 0, frame_stb = 0, zc_off = 0, auto_en = 1, clk_err = 0;
  logic [NCH*SW-1:0] smp_i = '0;
  logic [NCH*AW-1:0] att_req = '0;
  logic [NCH-1:0] mute_req = '0, req_ld = '0;
  logic [NCH*AW-1:0] att_o;
  logic [NCH-1:0] mute_o, acc;
  logic [NCH-1:0] em = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  zc_vol_ctrl u0 (.clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .smp_i(smp_i),
    .att_req(att_req), .mute_req(mute_req), .req_ld(req_ld), .zc_off(zc_off),
    .auto_en(auto_en), .clk_err(clk_err), .att_o(att_o), .mute_o(mute_o), .acc(acc));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int att(input int ch);
    return int'(att_o[ch*AW +: AW]);
  endfunction

  task automatic frame6(input logic [SW-1:0] a, b, c, d, e, f);
    @(negedge clk);
    smp_i = {f, e, d, c, b, a};
    frame_stb = 1;
    @(negedge clk);
    frame_stb = 0;
  endtask

  task automatic frame_all(input logic [SW-1:0] v);
    frame6(v, v, v, v, v, v);
  endtask

  task automatic ld(input int ch, input int a, input bit m);
    @(negedge clk);
    att_req[ch*AW +: AW] = AW'(a);
    mute_req[ch] = m;
    req_ld = NCH'(1) << ch;
    @(negedge clk);
    req_ld = '0;
  endtask

  task automatic t_reset;
    chk("R1 att", int'(att_o), 0);
    chk("R1 mute", int'(mute_o), 0);
    chk("R1 acc", int'(acc), 0);
  endtask

  task automatic t_immediate;
    zc_off = 1;
    ld(0, 10, 0);
    chk("R3 att0", att(0), 10);
    chk("R3 acc", int'(acc), 0);
    ld(1, 120, 0);
    chk("R2 clamp 120", att(1), 86);
    ld(2, 127, 0);
    chk("R2 clamp 127", att(2), 86);
    zc_off = 0;
  endtask

  task automatic t_sign_cross;
    frame_all(20'd100);
    ld(1, 20, 0);
    chk("R4 acc1 set", int'(acc[1]), 1);
    chk("R4 att1 held", att(1), 86);
    frame_all(20'd100);
    chk("R4 no cross", att(1), 86);
    frame6(20'd100, -20'sd5, 20'd100, 20'd100, 20'd100, 20'd100);
    chk("R4 sign cross att1", att(1), 20);
    chk("R4 acc1 clear", int'(acc[1]), 0);
    chk("R4 ch0 untouched", att(0), 10);
  endtask

  task automatic t_zero_cross;
    frame_all(20'd100);
    ld(2, 33, 0);
    frame6(20'd100, 20'd100, 20'd0, 20'd100, 20'd100, 20'd100);
    chk("R4 zero sample att2", att(2), 33);
    chk("R4 acc2 clear", int'(acc[2]), 0);
  endtask

  task automatic t_replace;
    ld(3, 30, 0);
    ld(3, 40, 0);
    chk("R5 acc3 kept", int'(acc[3]), 1);
    chk("R5 att3 held", att(3), 0);
    frame6(20'd100, 20'd100, 20'd100, 20'hFFFFF, 20'd100, 20'd100);
    chk("R5 replaced value", att(3), 40);
  endtask

  task automatic t_mute_defer;
    frame_all(20'd100);
    ld(4, 0, 1);
    chk("R6 mute4 deferred", int'(mute_o[4]), 0);
    chk("R6 acc4", int'(acc[4]), 1);
    frame_all(20'd100);
    chk("R6 mute4 still off", int'(mute_o[4]), 0);
    frame6(20'd100, 20'd100, 20'd100, 20'd100, -20'sd7, 20'd100);
    em[4] = 1;
    chk("R6 mute4 applied", int'(mute_o), int'(em));
  endtask

  task automatic t_force;
    frame_all(20'd100);
    ld(0, 55, 0);
    chk("R11 pending", int'(acc[0]), 1);
    zc_off = 1;
    @(negedge clk);
    chk("R11 att0", att(0), 55);
    chk("R11 acc0", int'(acc[0]), 0);
    zc_off = 0;
  endtask

  task automatic t_timeout;
    int n;
    frame_all(20'd100);
    ld(5, 50, 0);
    n = 0;
    for (int k = 1; k <= 1100; k++) begin
      frame_all(20'd100);
      if (!acc[5]) begin n = k; break; end
    end
    n_chk++;
    if (n < 512 || n > 1024) begin
      n_bad++;
      $display("FAIL R7 timeout frames: actual %0d expected 512..1024", n);
    end
    chk("R7 att5", att(5), 50);
  endtask

  task automatic t_auto;
    auto_en = 1;
    for (int k = 0; k < 511; k++) frame_all(20'd0);
    chk("R8 after 511", int'(mute_o), int'(em));
    frame_all(20'd0);
    chk("R8 after 512", int'(mute_o), 63);
    frame_all(20'hFFFFF);
    chk("R8 minus one silent", int'(mute_o), 63);
    frame6(20'd3, 20'd0, 20'd0, 20'd0, 20'd0, 20'd0);
    chk("R8 release", int'(mute_o), int'(em));
  endtask

  task automatic t_auto_off;
    auto_en = 0;
    for (int k = 0; k < 600; k++) frame_all(20'd0);
    chk("R9 disabled", int'(mute_o), int'(em));
    frame_all(20'd100);
    auto_en = 1;
  endtask

  task automatic t_clk_err;
    @(negedge clk);
    clk_err = 1;
    #1;
    chk("R10 error mute", int'(mute_o), 63);
    clk_err = 0;
    #1;
    chk("R10 error release", int'(mute_o), int'(em));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_immediate;
    t_sign_cross;
    t_zero_cross;
    t_replace;
    t_mute_defer;
    t_force;
    t_clk_err;
    t_timeout;
    t_auto;
    t_auto_off;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule